// File: doc/BRIEF.md
# Shortcut-Aware Route Selector

This unit sits in the header path of a torus router. For every message header it is given the current node and the destination. It decides whether the message should cross one of three fixed long-range shortcut links or stay on the wired torus. It returns four things: the output port for the next hop, a flag that selects the routing discipline, the index of the chosen shortcut, and the hop count of the chosen path.

The shortcut endpoints are fixed by parameters and never change at run time. Each shortcut spans half the ring of one column, and the three columns are spread evenly around the x ring. The unit computes the wired torus distance. It also computes the cost through each shortcut, in whichever direction is cheaper, and keeps the smallest. Wired-only messages take dimension-ordered (x then y) steps. Messages bound for a shortcut steer toward its entry node with south moves deferred to last, so that the shortcut path stays free of deadlock.

The decision is registered. A header accepted on one clock edge produces its result on that same edge, and the result stays on the output until the consumer takes it.

Top module: `shortcut_route_sel`

## Requirements
- R1: During and directly after reset, out_valid is 0 and in_ready is 1.
- R2: A header accepted (in_valid and in_ready high at an edge) appears on the outputs with out_valid=1 after that same edge. While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold. When out_valid=1 and out_ready=1, a header offered in the same cycle replaces the result; otherwise out_valid returns to 0.
- R3: The grid is GRID_W by GRID_H (x east-positive, y north-positive, both wrapping). Shortcut k (k=0,1,2) joins (k*GRID_W/3 + GRID_W/6, 0) with the same column at row GRID_H/2, which on the default 16x16 grid gives columns 2, 7 and 12 between rows 0 and 8. A message may cross a shortcut in either direction.
- R4: Wired cost is the shorter ring distance in x plus the shorter ring distance in y.
- R5: Shortcut cost is the wired cost from the current node to the entry end, plus 1, plus the wired cost from the other end to the destination. When both directions cost the same, the message enters at the row-0 end.
- R6: A shortcut is chosen only when its cost is strictly below the wired cost. Among shortcuts of equal cost, the lowest index wins. out_via is 1 exactly when a shortcut is chosen, and out_link is its index, or 0 when no shortcut is chosen.
- R7: out_hops equals the cost of the chosen path, 0 when the current node is the destination.
- R8: Direction codes are 0 local, 1 east (+x), 2 west, 3 north (+y), 4 south, 5 shortcut port. On a wired path the unit resolves x before y and takes the shorter way around each ring. At exactly half a ring it picks east or north. At the destination it gives local.
- R9: On a shortcut path (out_via=1), the target is the entry node and the direction is 5 at the entry node. Otherwise the unit goes north if y needs a north step, else x (shorter way, east on a half-ring tie), else south.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be accepted this cycle |
| in_cur_x | input | $clog2(GRID_W) | Current node x |
| in_cur_y | input | $clog2(GRID_H) | Current node y |
| in_dst_x | input | $clog2(GRID_W) | Destination x |
| in_dst_y | input | $clog2(GRID_H) | Destination y |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_dir | output | 3 | Next-hop port code (R8) |
| out_via | output | 1 | 1 = shortcut path with south-last discipline, 0 = wired x-then-y |
| out_link | output | 2 | Chosen shortcut index |
| out_hops | output | $clog2(GRID_W/2+GRID_H/2+1) | Hop count of the chosen path |

## Verification
The bench sweeps every current/destination pair of the 16x16 grid against an independent hop-count model. A wrong wrap distance, a missed shortcut direction or an off-by-one shortcut cost would show up there as a wrong hop count or a wrong wired/shortcut choice. Directed vectors cover the specific corners:
- Two shortcuts at equal cost across the x wrap. A selector that lets the later index win reports link 2 instead of 0.
- Exact half-ring distances in x and y. A wrong tie rule steers west or south.
- A shortcut route that needs both north and west. An x-first discipline would answer west where south-last answers north.
- Headers sitting on a shortcut endpoint, which must get the shortcut port.
- A held output under back-pressure. A design that overwrites it loses the first decision.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NUM_LINKS = 3;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_WEST  = 3'd2,
        DIR_NORTH = 3'd3,
        DIR_SOUTH = 3'd4,
        DIR_LINK  = 3'd5
    } dir_e;

    typedef struct packed {
        dir_e       dir;
        logic       via;
        logic [1:0] link;
    } route_head_t;

    // shorter distance between two positions on a ring of n nodes
    function automatic int ring_dist(int a, int b, int n);
        int d;
        d = (a >= b) ? a - b : b - a;
        return (d > n - d) ? n - d : d;
    endfunction

    // 1 when the positive direction is taken from a to b (ties go positive)
    function automatic logic ring_pos(int a, int b, int n);
        int f;
        f = (b >= a) ? b - a : b - a + n;
        return (2 * f <= n);
    endfunction

    // column of shortcut k, spread evenly around the x ring
    function automatic int link_col(int k, int w);
        return (k * w) / NUM_LINKS + w / (2 * NUM_LINKS);
    endfunction

endpackage

// File: rtl/rs_link_cost.sv
module rs_link_cost
    import rs_pkg::*;
#(
    parameter int GRID_W = 16,
    parameter int GRID_H = 16,
    parameter int LINK   = 0,
    parameter int XW     = 4,
    parameter int YW     = 4,
    parameter int CW     = 6
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic [CW-1:0] cost,
    output logic [XW-1:0] ent_x,
    output logic [YW-1:0] ent_y
);
    localparam int COL   = link_col(LINK, GRID_W);
    localparam int ROW_B = GRID_H / 2;

    always_comb begin
        int via_a;
        int via_b;
        via_a = ring_dist(int'(cur_x), COL, GRID_W) + ring_dist(int'(cur_y), 0, GRID_H)
              + 1
              + ring_dist(COL, int'(dst_x), GRID_W) + ring_dist(ROW_B, int'(dst_y), GRID_H);
        via_b = ring_dist(int'(cur_x), COL, GRID_W) + ring_dist(int'(cur_y), ROW_B, GRID_H)
              + 1
              + ring_dist(COL, int'(dst_x), GRID_W) + ring_dist(0, int'(dst_y), GRID_H);
        ent_x = XW'(COL);
        if (via_b < via_a) begin
            cost  = CW'(via_b);
            ent_y = YW'(ROW_B);
        end else begin
            cost  = CW'(via_a);
            ent_y = '0;
        end
    end
endmodule

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pkg::*;
#(
    parameter int CW = 6,
    parameter int IW = 2
) (
    input  logic [CW-1:0] wired_cost,
    input  logic [CW-1:0] link_cost [NUM_LINKS],
    output logic          via,
    output logic [IW-1:0] link,
    output logic [CW-1:0] best
);
    always_comb begin
        best = wired_cost;
        via  = 1'b0;
        link = '0;
        // strict compare: wired wins ties, lower index wins among links
        for (int k = 0; k < NUM_LINKS; k++) begin
            if (link_cost[k] < best) begin
                best = link_cost[k];
                via  = 1'b1;
                link = IW'(k);
            end
        end
    end
endmodule

// File: rtl/rs_next_hop.sv
module rs_next_hop
    import rs_pkg::*;
#(
    parameter int GRID_W = 16,
    parameter int GRID_H = 16,
    parameter int XW     = 4,
    parameter int YW     = 4
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] tgt_x,
    input  logic [YW-1:0] tgt_y,
    input  logic          south_last,
    output dir_e          dir
);
    logic need_x, need_y, go_east, go_north;

    always_comb begin
        need_x   = (cur_x != tgt_x);
        need_y   = (cur_y != tgt_y);
        go_east  = ring_pos(int'(cur_x), int'(tgt_x), GRID_W);
        go_north = ring_pos(int'(cur_y), int'(tgt_y), GRID_H);
        if (!need_x && !need_y) begin
            dir = south_last ? DIR_LINK : DIR_LOCAL;
        end else if (south_last) begin
            if (need_y && go_north)
                dir = DIR_NORTH;
            else if (need_x)
                dir = go_east ? DIR_EAST : DIR_WEST;
            else
                dir = DIR_SOUTH;
        end else begin
            if (need_x)
                dir = go_east ? DIR_EAST : DIR_WEST;
            else
                dir = go_north ? DIR_NORTH : DIR_SOUTH;
        end
    end
endmodule

// File: rtl/shortcut_route_sel.sv
module shortcut_route_sel
    import rs_pkg::*;
#(
    parameter int GRID_W = 16,
    parameter int GRID_H = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    in_valid,
    output logic                                    in_ready,
    input  logic [$clog2(GRID_W)-1:0]               in_cur_x,
    input  logic [$clog2(GRID_H)-1:0]               in_cur_y,
    input  logic [$clog2(GRID_W)-1:0]               in_dst_x,
    input  logic [$clog2(GRID_H)-1:0]               in_dst_y,
    output logic                                    out_valid,
    input  logic                                    out_ready,
    output logic [2:0]                              out_dir,
    output logic                                    out_via,
    output logic [1:0]                              out_link,
    output logic [$clog2(GRID_W/2+GRID_H/2+1)-1:0]  out_hops
);
    localparam int XW = $clog2(GRID_W);
    localparam int YW = $clog2(GRID_H);
    localparam int CW = $clog2(GRID_W + GRID_H + 2);
    localparam int HW = $clog2(GRID_W/2 + GRID_H/2 + 1);
    localparam int IW = 2;

    logic [CW-1:0] wired_cost;
    logic [CW-1:0] lk_cost [NUM_LINKS];
    logic [XW-1:0] lk_x    [NUM_LINKS];
    logic [YW-1:0] lk_y    [NUM_LINKS];

    always_comb begin
        wired_cost = CW'(ring_dist(int'(in_cur_x), int'(in_dst_x), GRID_W)
                       + ring_dist(int'(in_cur_y), int'(in_dst_y), GRID_H));
    end

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        rs_link_cost #(
            .GRID_W(GRID_W), .GRID_H(GRID_H), .LINK(g),
            .XW(XW), .YW(YW), .CW(CW)
        ) u_cost (
            .cur_x(in_cur_x), .cur_y(in_cur_y),
            .dst_x(in_dst_x), .dst_y(in_dst_y),
            .cost(lk_cost[g]), .ent_x(lk_x[g]), .ent_y(lk_y[g])
        );
    end

    logic          sel_via;
    logic [IW-1:0] sel_link;
    logic [CW-1:0] sel_cost;

    rs_pick #(.CW(CW), .IW(IW)) u_pick (
        .wired_cost(wired_cost), .link_cost(lk_cost),
        .via(sel_via), .link(sel_link), .best(sel_cost)
    );

    logic [XW-1:0] tgt_x;
    logic [YW-1:0] tgt_y;

    always_comb begin
        tgt_x = in_dst_x;
        tgt_y = in_dst_y;
        for (int k = 0; k < NUM_LINKS; k++) begin
            if (sel_via && sel_link == IW'(k)) begin
                tgt_x = lk_x[k];
                tgt_y = lk_y[k];
            end
        end
    end

    dir_e nh_dir;

    rs_next_hop #(.GRID_W(GRID_W), .GRID_H(GRID_H), .XW(XW), .YW(YW)) u_hop (
        .cur_x(in_cur_x), .cur_y(in_cur_y),
        .tgt_x(tgt_x), .tgt_y(tgt_y),
        .south_last(sel_via), .dir(nh_dir)
    );

    route_head_t   head_q;
    logic [HW-1:0] hops_q;

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            head_q    <= '0;
            hops_q    <= '0;
        end else if (in_valid && in_ready) begin
            out_valid   <= 1'b1;
            head_q.dir  <= nh_dir;
            head_q.via  <= sel_via;
            head_q.link <= sel_link;
            hops_q      <= HW'(sel_cost);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_dir  = head_q.dir;
    assign out_via  = head_q.via;
    assign out_link = head_q.link;
    assign out_hops = hops_q;
endmodule

// File: rtl/rs_checks.sv
module rs_checks #(
    parameter int GRID_W = 16,
    parameter int GRID_H = 16
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   in_valid,
    input logic                                   in_ready,
    input logic                                   out_valid,
    input logic                                   out_ready,
    input logic [2:0]                             out_dir,
    input logic                                   out_via,
    input logic [1:0]                             out_link,
    input logic [$clog2(GRID_W/2+GRID_H/2+1)-1:0] out_hops
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R2

    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_dir) && $stable(out_via)
                                    && $stable(out_link) && $stable(out_hops)); // R2

    AST_LINK_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_via |-> out_link < 2'd3 && out_hops != '0); // R6

    AST_WIRED_IDX: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_via |-> out_link == 2'd0 && out_dir != 3'd5); // R6

    AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_dir == 3'd0 |-> !out_via && out_hops == '0); // R7

    AST_PORT_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_dir <= 3'd5); // R8

    AST_LINK_PORT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_dir == 3'd5 |-> out_via); // R9
endmodule

bind shortcut_route_sel rs_checks #(.GRID_W(GRID_W), .GRID_H(GRID_H)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
    .out_via(out_via), .out_link(out_link), .out_hops(out_hops)
);

// File: tb/tb_shortcut_route_sel.sv
`timescale 1ns/1ps
module tb_shortcut_route_sel;
    localparam int W = 16;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_cur_x = '0, in_cur_y = '0, in_dst_x = '0, in_dst_y = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [2:0] out_dir;
    logic       out_via;
    logic [1:0] out_link;
    logic [4:0] out_hops;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shortcut_route_sel #(.GRID_W(W), .GRID_H(H)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cur_x(in_cur_x), .in_cur_y(in_cur_y), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
        .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
        .out_via(out_via), .out_link(out_link), .out_hops(out_hops)
    );

    typedef struct packed {
        logic [3:0] cx, cy, dx, dy;
        logic [2:0] dir;
        logic       via;
        logic [1:0] link;
        logic [4:0] hops;
    } vec_t;

    // cur x,y / dst x,y / dir / via / link / hops
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  4'd0, 4'd0,  4'd0,  3'd0, 1'b0, 2'd0, 5'd0},  // R7 R8 local
        '{4'd0,  4'd0, 4'd3,  4'd0,  3'd1, 1'b0, 2'd0, 5'd3},  // R4 east
        '{4'd2,  4'd0, 4'd2,  4'd8,  3'd5, 1'b1, 2'd0, 5'd1},  // R3 link 0 at entry
        '{4'd7,  4'd1, 4'd7,  4'd9,  3'd4, 1'b1, 2'd1, 5'd3},  // R9 south to entry
        '{4'd3,  4'd1, 4'd2,  4'd9,  3'd2, 1'b1, 2'd0, 5'd4},  // R9 west before south
        '{4'd15, 4'd0, 4'd15, 4'd8,  3'd1, 1'b1, 2'd0, 5'd7},  // R6 equal links, lowest index
        '{4'd0,  4'd0, 4'd8,  4'd0,  3'd1, 1'b0, 2'd0, 5'd8},  // R8 half ring x -> east
        '{4'd5,  4'd4, 4'd5,  4'd12, 3'd3, 1'b0, 2'd0, 5'd8},  // R8 half ring y -> north
        '{4'd0,  4'd0, 4'd13, 4'd0,  3'd2, 1'b0, 2'd0, 5'd3},  // R4 wrap west
        '{4'd5,  4'd5, 4'd5,  4'd3,  3'd4, 1'b0, 2'd0, 5'd2},  // R8 south wired
        '{4'd3,  4'd6, 4'd2,  4'd1,  3'd3, 1'b1, 2'd0, 5'd5},  // R5 R9 enter at far end, north first
        '{4'd12, 4'd8, 4'd12, 4'd0,  3'd5, 1'b1, 2'd2, 5'd1},  // R3 link 2 reverse
        '{4'd7,  4'd0, 4'd7,  4'd8,  3'd5, 1'b1, 2'd1, 5'd1}   // R3 link 1
    };

    function automatic int rd(int a, int b, int n);
        int d = (a > b) ? a - b : b - a;
        return (2 * d > n) ? n - d : d;
    endfunction

    function automatic bit pos_way(int a, int b, int n);
        int f = (b - a + n) % n;
        return (2 * f <= n);
    endfunction

    // reference model: returns {dir, via, link, hops}
    function automatic logic [10:0] model(int cx, int cy, int dx, int dy);
        int best, bl, tx, ty, dir, col, ca, cb;
        bit via;
        best = rd(cx, dx, W) + rd(cy, dy, H);
        via = 0; bl = 0; tx = dx; ty = dy;
        for (int k = 0; k < 3; k++) begin
            col = k * W / 3 + W / 6;
            ca = rd(cx, col, W) + cy + 0 + 1 + rd(col, dx, W) + rd(H / 2, dy, H);
            ca = rd(cx, col, W) + rd(cy, 0, H) + 1 + rd(col, dx, W) + rd(H / 2, dy, H);
            cb = rd(cx, col, W) + rd(cy, H / 2, H) + 1 + rd(col, dx, W) + rd(0, dy, H);
            if (ca < best) begin best = ca; via = 1; bl = k; tx = col; ty = 0; end
            if (cb < best) begin best = cb; via = 1; bl = k; tx = col; ty = H / 2; end
        end
        if (cx == tx && cy == ty) dir = via ? 5 : 0;
        else if (via) begin
            if (cy != ty && pos_way(cy, ty, H)) dir = 3;
            else if (cx != tx) dir = pos_way(cx, tx, W) ? 1 : 2;
            else dir = 4;
        end else begin
            if (cx != tx) dir = pos_way(cx, tx, W) ? 1 : 2;
            else dir = pos_way(cy, ty, H) ? 3 : 4;
        end
        return {3'(dir), via, 2'(bl), 5'(best)};
    endfunction

    task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got dir/via/link/hops=%h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [10:0] outs();
        return {out_dir, out_via, out_link, out_hops};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [10:0] prev;
        repeat (3) @(negedge clk);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 out_valid after reset", out_valid, 1'b0);
        check_bit("R1 in_ready after reset", in_ready, 1'b1);

        // directed vector table
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_cur_x = VECS[i].cx; in_cur_y = VECS[i].cy;
            in_dst_x = VECS[i].dx; in_dst_y = VECS[i].dy;
            @(negedge clk);
            in_valid = 1'b0;
            check_bit("R2 out_valid after accept", out_valid, 1'b1);
            check($sformatf("R6 R8 R9 vector %0d", i), outs(),
                  {VECS[i].dir, VECS[i].via, VECS[i].link, VECS[i].hops});
        end
        @(negedge clk);
        check_bit("R2 out_valid drops when consumed", out_valid, 1'b0);

        // back-pressure: first result must hold, second waits
        out_ready = 1'b0;
        in_valid = 1'b1;
        in_cur_x = 4'd7; in_cur_y = 4'd1; in_dst_x = 4'd7; in_dst_y = 4'd9;
        @(negedge clk);
        in_cur_x = 4'd0; in_cur_y = 4'd0; in_dst_x = 4'd13; in_dst_y = 4'd0;
        #1;
        check_bit("R2 in_ready low while held", in_ready, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 held result", outs(), {3'd4, 1'b1, 2'd1, 5'd3});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 queued header taken on release", outs(), {3'd2, 1'b0, 2'd0, 5'd3});
        @(negedge clk);
        check_bit("R2 idle after release", out_valid, 1'b0);

        // exhaustive sweep, one header per cycle
        prev = '0;
        for (int p = 0; p < W * H * W * H; p++) begin
            in_valid = 1'b1;
            in_cur_x = 4'(p >> 12); in_cur_y = 4'(p >> 8);
            in_dst_x = 4'(p >> 4);  in_dst_y = 4'(p);
            prev = model(p >> 12, (p >> 8) & 15, (p >> 4) & 15, p & 15);
            @(negedge clk);
            if (outs() !== prev || out_valid !== 1'b1) begin
                check($sformatf("R4 R5 R6 R7 sweep %0d", p), outs(), prev);
            end else begin
                checks++;
            end
        end
        in_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule